// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that counts down at a prescaled rate from a programmable top value. Software must service it at the right time. A service is a two-word unlock-and-kick sequence on a write port. It is honoured only while the current count sits inside the permitted part of the count range.

The count range is split into four equal quarters. A 4-bit mask chooses which quarters accept a service, so the permitted region may be one piece or two separate pieces. A service outside that region is a fault, and so is reaching underflow. A fault either raises a level interrupt or emits a one-cycle reset request.

All options come from a static configuration word that is captured while reset is asserted and frozen afterwards. The options are:
- starting automatically or waiting for the first service;
- the fault action;
- the period;
- the clock divider;
- the window mask;
- freezing the count during sleep.

Top module: `win_watchdog`

## Requirements
- R1: While `rst_n` is low the configuration word is captured. After release with auto-start, `count_o` equals the period minus one, `flags_o` is 0, `irq_o` and `rst_req_o` are low, and `running_o` is high.
- R2: The period code is configuration bits [3:2], with 00=256, 01=4096, 10=16384 and 11=65536 counting ticks. The count drops by one per tick. On the tick that finds the count at 0, underflow flag `flags_o[0]` is set and the count reloads to period minus one.
- R3: The divider code is configuration bits [7:4], with 0000=/1, 0100=/16, 0101=/32, 0110=/64, 0111=/128, 1000=/256 and 1011=/2048. Every other code divides by 1. After N enabled clocks from reset, the count has dropped by floor(N/divisor).
- R4: The window mask is configuration bits [11:8]. Bit k permits a service while the count c lies in quarter k. Quarter 0 is c <= P/4, quarter 1 is P/4 < c <= P/2, quarter 2 is P/2 < c <= 3P/4 and quarter 3 is c > 3P/4, where P is the period.
- R5: A window mask of 0000 permits a service at any count.
- R6: A service is a write of 0x0123 followed, on the very next write, by 0x3210. A permitted service reloads the count to P-1. A sequence broken by any other write does nothing.
- R7: A completed service outside every enabled quarter sets error flag `flags_o[1]` and leaves the count running.
- R8: Configuration bit [1] selects the fault action. At 0, `irq_o` is high while any flag is set. At 1, `irq_o` stays low and each fault gives a `rst_req_o` pulse exactly one cycle long.
- R9: A write on `clr_we_i` clears each flag whose bit is 1 in `clr_mask_i`. Flags otherwise hold.
- R10: With configuration bit [0] at 1, the counter holds at P-1 with `running_o` low. The first completed service starts it, regardless of the window.
- R11: With configuration bit [12] at 1, the count holds while `sleep_i` is high. With it at 0, sleep has no effect.
- R12: The count advances only in cycles where `cnt_en_i` is high.
- R13: A permitted service in the cycle of an underflow tick wins, so no underflow flag is set. A refused service in that cycle sets both flags, and the count reloads.
- R14: Changing `cfg_i` after reset has no effect on period, action or any other option.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, captures configuration |
| cfg_i | input | 13 | Static configuration word |
| cnt_en_i | input | 1 | Clock enable of the counting clock |
| sleep_i | input | 1 | Low-power state indication |
| kick_we_i | input | 1 | Service write strobe |
| kick_data_i | input | 16 | Service write data |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 2 | Write-1-to-clear mask for flags |
| flags_o | output | 2 | Bit0 underflow, bit1 refresh error |
| count_o | output | 16 | Current count |
| running_o | output | 1 | Counter has started |
| irq_o | output | 1 | Level interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
An underflow tick and the completion of a service can fall in the same cycle. The bench provokes this by writing the first key while the count reads 1, so that the second key arrives exactly when the count is 0 and a tick is due. It then judges the flags and the count at the next falling edge. With a mask covering quarter 0, the service must win and no flag may appear. With a mask covering only quarter 3, both flags must be set, the count must be back at its top, and in reset mode a single request pulse must follow.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

   localparam int CFG_W = 13;

   typedef struct packed {
      logic       frz_sleep;
      logic [3:0] win;
      logic [3:0] div;
      logic [1:0] per;
      logic       act_rst;
      logic       hold;
   } wd_cfg_t;

   // log2 of the period in counting ticks
   function automatic logic [4:0] per_shift(input logic [1:0] code);
      case (code)
         2'b00:   return 5'd8;
         2'b01:   return 5'd12;
         2'b10:   return 5'd14;
         default: return 5'd16;
      endcase
   endfunction

   // log2 of the clock divider; unlisted codes divide by one
   function automatic logic [3:0] div_shift(input logic [3:0] code);
      case (code)
         4'b0100: return 4'd4;
         4'b0101: return 4'd5;
         4'b0110: return 4'd6;
         4'b0111: return 4'd7;
         4'b1000: return 4'd8;
         4'b1011: return 4'd11;
         default: return 4'd0;
      endcase
   endfunction

endpackage

// File: rtl/wwdt_presc.sv
module wwdt_presc #(
   parameter int DIV_W = 11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic [3:0] shift,
   output logic       tick
);

   if (DIV_W < 11) begin : g_bad_div
      $error("wwdt_presc: DIV_W must cover a divide by 2048");
   end

   logic [DIV_W-1:0] acc_q;
   logic [DIV_W-1:0] lim;
   logic [DIV_W:0]   span;

   assign span = (DIV_W+1)'(1) << shift;
   assign lim  = DIV_W'(span - 1'b1);
   assign tick = active && (acc_q == lim);

   always_ff @(posedge clk) begin
      if (!rst_n)      acc_q <= '0;
      else if (active) acc_q <= tick ? '0 : acc_q + 1'b1;
   end

   // R3
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && lim != '0) |=> !tick);

endmodule

// File: rtl/wwdt_window.sv
module wwdt_window #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [4:0]       per_sh,
   input  logic [3:0]       mask,
   output logic             ok
);

   localparam int NQ = 4;

   logic [CNT_W:0] full, qtr, cx;
   logic [NQ-1:0]  in_q;

   assign full = (CNT_W+1)'(1) << per_sh;
   assign qtr  = full >> 2;
   assign cx   = {1'b0, count};

   for (genvar q = 0; q < NQ; q++) begin : g_qtr
      logic [CNT_W:0] lo, hi;
      logic           above, below;
      assign lo    = (CNT_W+1)'(q) * qtr;
      assign hi    = (CNT_W+1)'(q + 1) * qtr;
      if (q == 0) begin : g_first
         assign above = 1'b1;
      end else begin : g_rest
         assign above = cx > lo;
      end
      if (q == NQ-1) begin : g_last
         assign below = 1'b1;
      end else begin : g_mid
         assign below = cx <= hi;
      end
      assign in_q[q] = above && below;
   end

   assign ok = (mask == '0) || |(in_q & mask);

   // R4
   quarter_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(in_q) == 1);

endmodule

// File: rtl/wwdt_key.sv
module wwdt_key #(
   parameter int               DATA_W = 16,
   parameter logic [DATA_W-1:0] KEY_A = 'h0123,
   parameter logic [DATA_W-1:0] KEY_B = 'h3210
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] data,
   output logic              fire
);

   if (KEY_A == KEY_B) begin : g_bad_key
      $error("wwdt_key: the two keys must differ");
   end

   logic armed_q;

   assign fire = we && armed_q && (data == KEY_B);

   always_ff @(posedge clk) begin
      if (!rst_n)  armed_q <= 1'b0;
      else if (we) armed_q <= (data == KEY_A);
   end

   // R6
   key_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $past(we && data == KEY_A));

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
   import wwdt_pkg::*;
#(
   parameter int               CNT_W  = 16,
   parameter int               DIV_W  = 11,
   parameter int               DATA_W = 16,
   parameter logic [DATA_W-1:0] KEY_A = 'h0123,
   parameter logic [DATA_W-1:0] KEY_B = 'h3210
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_W-1:0]  cfg_i,
   input  logic              cnt_en_i,
   input  logic              sleep_i,
   input  logic              kick_we_i,
   input  logic [DATA_W-1:0] kick_data_i,
   input  logic              clr_we_i,
   input  logic [1:0]        clr_mask_i,
   output logic [1:0]        flags_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              running_o,
   output logic              irq_o,
   output logic              rst_req_o
);

   if (CNT_W < 16) begin : g_bad_cnt
      $error("win_watchdog: CNT_W must hold a 65536 period");
   end

   function automatic logic [CNT_W-1:0] top_of(input logic [4:0] sh);
      logic [CNT_W:0] f;
      f = (CNT_W+1)'(1) << sh;
      return CNT_W'(f - 1'b1);
   endfunction

   wd_cfg_t          cfg_in, cfg_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q, rreq_q;
   logic [1:0]       flg_q;
   logic             active, tick, fire, win_ok;
   logic             kick_ok, kick_bad, uflow;
   logic [4:0]       per_sh;

   assign cfg_in = wd_cfg_t'(cfg_i);
   assign per_sh = per_shift(cfg_q.per);
   assign active = run_q && cnt_en_i && !(cfg_q.frz_sleep && sleep_i);

   wwdt_presc #(.DIV_W(DIV_W)) i_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .active(active),
      .shift (div_shift(cfg_q.div)),
      .tick  (tick)
   );

   wwdt_window #(.CNT_W(CNT_W)) i_window (
      .clk   (clk),
      .rst_n (rst_n),
      .count (cnt_q),
      .per_sh(per_sh),
      .mask  (cfg_q.win),
      .ok    (win_ok)
   );

   wwdt_key #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) i_key (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (kick_we_i),
      .data (kick_data_i),
      .fire (fire)
   );

   assign kick_ok  = fire && (!run_q || win_ok);
   assign kick_bad = fire && run_q && !win_ok;
   assign uflow    = tick && (cnt_q == '0) && !kick_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= cfg_in;
         cnt_q  <= top_of(per_shift(cfg_in.per));
         run_q  <= !cfg_in.hold;
         flg_q  <= '0;
         rreq_q <= 1'b0;
      end else begin
         if (kick_ok)               cnt_q <= top_of(per_sh);
         else if (tick)             cnt_q <= (cnt_q == '0) ? top_of(per_sh) : cnt_q - 1'b1;
         run_q    <= run_q || kick_ok;
         flg_q[0] <= (flg_q[0] && !(clr_we_i && clr_mask_i[0])) || uflow;
         flg_q[1] <= (flg_q[1] && !(clr_we_i && clr_mask_i[1])) || kick_bad;
         rreq_q   <= cfg_q.act_rst && (uflow || kick_bad);
      end
   end

   assign flags_o   = flg_q;
   assign count_o   = cnt_q;
   assign running_o = run_q;
   assign irq_o     = !cfg_q.act_rst && (flg_q != '0);
   assign rst_req_o = rreq_q;

   // R2
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_q != '0 && !kick_ok) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
   // R12
   gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en_i && !kick_ok) |=> $stable(cnt_q));
   // R8
   pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);
   // R9
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[0] && !(clr_we_i && clr_mask_i[0])) |=> flags_o[0]);
   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running_o && !fire) |=> $stable(cnt_q) && !running_o);
   // R11
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.frz_sleep && sleep_i && !kick_ok) |=> $stable(cnt_q));
   // R13
   collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kick_ok && !flags_o[0]) |=> !flags_o[0]);

endmodule

// File: tb/test_win_watchdog.sv
module test_win_watchdog;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] cfg_i = '0;
   logic        cnt_en_i = 1'b1;
   logic        sleep_i = 1'b0;
   logic        kick_we_i = 1'b0;
   logic [15:0] kick_data_i = '0;
   logic        clr_we_i = 1'b0;
   logic [1:0]  clr_mask_i = '0;
   logic [1:0]  flags_o;
   logic [15:0] count_o;
   logic        running_o, irq_o, rst_req_o;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   win_watchdog i_win_watchdog (
      .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .cnt_en_i(cnt_en_i),
      .sleep_i(sleep_i), .kick_we_i(kick_we_i), .kick_data_i(kick_data_i),
      .clr_we_i(clr_we_i), .clr_mask_i(clr_mask_i), .flags_o(flags_o),
      .count_o(count_o), .running_o(running_o), .irq_o(irq_o),
      .rst_req_o(rst_req_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [12:0] mk(input logic frz, input logic [3:0] win,
      input logic [3:0] dv, input logic [1:0] per, input logic act, input logic hold);
      return {frz, win, dv, per, act, hold};
   endfunction

   function automatic int qof(input int c, input int p);
      if (c <= p/4)   return 0;
      if (c <= p/2)   return 1;
      if (c <= 3*p/4) return 2;
      return 3;
   endfunction

   task automatic do_reset(input logic [12:0] c);
      @(negedge clk);
      rst_n = 1'b0; cfg_i = c; kick_we_i = 1'b0; clr_we_i = 1'b0;
      cnt_en_i = 1'b1; sleep_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic kick(input logic [15:0] d);
      kick_we_i = 1'b1; kick_data_i = d;
      @(negedge clk);
      kick_we_i = 1'b0;
   endtask

   task automatic wait_count(input int v);
      while (int'(count_o) != v) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      // R1 and R2: reset state and top value for every period code
      for (int pc = 0; pc < 4; pc++) begin
         int p;
         p = (pc == 0) ? 256 : (pc == 1) ? 4096 : (pc == 2) ? 16384 : 65536;
         do_reset(mk(0, 4'h0, 4'h0, 2'(pc), 0, 0));
         chk("R1 R2 reset count", count_o, p - 1);
         chk("R1 flags", flags_o, 0);
         chk("R1 irq/req/run", {irq_o, rst_req_o, running_o}, 3'b001);
      end

      // R2 underflow after exactly P ticks, interrupt mode (R8)
      for (int pc = 0; pc < 2; pc++) begin
         int p;
         p = (pc == 0) ? 256 : 4096;
         do_reset(mk(0, 4'h0, 4'h0, 2'(pc), 0, 0));
         repeat (p - 1) @(negedge clk);
         chk("R2 count at zero", count_o, 0);
         chk("R2 no flag before", flags_o, 0);
         @(negedge clk);
         chk("R2 underflow flag", flags_o, 2'b01);
         chk("R2 reload", count_o, p - 1);
         chk("R8 irq level", irq_o, 1);
         // R9 clear with mask 10 keeps the flag, 01 clears it
         clr_we_i = 1'b1; clr_mask_i = 2'b10;
         @(negedge clk);
         chk("R9 wrong bit no clear", flags_o, 2'b01);
         clr_mask_i = 2'b01;
         @(negedge clk);
         clr_we_i = 1'b0;
         chk("R9 cleared", flags_o, 0);
         chk("R8 irq drops", irq_o, 0);
      end

      // R8 reset mode
      do_reset(mk(0, 4'h0, 4'h0, 2'b00, 1, 0));
      repeat (256) @(negedge clk);
      chk("R8 req pulse", rst_req_o, 1);
      chk("R8 no irq in reset mode", irq_o, 0);
      chk("R8 flag recorded", flags_o, 2'b01);
      @(negedge clk);
      chk("R8 pulse one cycle", rst_req_o, 0);

      // R3 divider sweep over all sixteen codes, period 65536
      for (int dc = 0; dc < 16; dc++) begin
         int d;
         case (dc)
            4: d = 16; 5: d = 32; 6: d = 64; 7: d = 128;
            8: d = 256; 11: d = 2048; default: d = 1;
         endcase
         do_reset(mk(0, 4'h0, 4'(dc), 2'b11, 0, 0));
         repeat (2100) @(negedge clk);
         chk($sformatf("R3 divider code %0d", dc), count_o, 65535 - 2100 / d);
      end

      // R4 R5 R7 window sweep, period 256, all masks, boundary counts
      begin
         int tg[8];
         tg = '{1, 64, 65, 128, 129, 192, 193, 254};
         for (int m = 0; m < 16; m++) begin
            for (int i = 0; i < 8; i++) begin
               bit okw;
               okw = (m == 0) || (((m >> qof(tg[i], 256)) & 1) == 1);
               do_reset(mk(0, 4'(m), 4'h0, 2'b00, 0, 0));
               wait_count(tg[i] + 1);
               kick(16'h0123);
               kick(16'h3210);
               if (okw) begin
                  chk($sformatf("R4 R5 ok m=%0h c=%0d count", m, tg[i]), count_o, 255);
                  chk("R4 ok no flag", flags_o, 0);
               end else begin
                  chk($sformatf("R7 refused m=%0h c=%0d count", m, tg[i]), count_o, tg[i] - 1);
                  chk("R7 error flag", flags_o, 2'b10);
                  chk("R7 irq", irq_o, 1);
               end
            end
         end
      end

      // R6 broken sequence ignored
      do_reset(mk(0, 4'h0, 4'h0, 2'b00, 0, 0));
      wait_count(200);
      kick(16'h0123);
      kick(16'h5555);
      kick(16'h3210);
      chk("R6 broken sequence", count_o, 197);
      chk("R6 no flag", flags_o, 0);
      kick(16'h0123);
      kick(16'h3210);
      chk("R6 good sequence", count_o, 255);

      // R10 software start, outside window still starts
      do_reset(mk(0, 4'b0001, 4'h0, 2'b00, 0, 1));
      repeat (100) @(negedge clk);
      chk("R10 held count", count_o, 255);
      chk("R10 not running", running_o, 0);
      kick(16'h0123);
      kick(16'h3210);
      chk("R10 started", running_o, 1);
      chk("R10 no error", flags_o, 0);
      repeat (5) @(negedge clk);
      chk("R10 counting", count_o, 250);

      // R11 sleep freeze and sleep pass-through
      do_reset(mk(1, 4'h0, 4'h0, 2'b00, 0, 0));
      repeat (10) @(negedge clk);
      sleep_i = 1'b1;
      repeat (50) @(negedge clk);
      chk("R11 frozen in sleep", count_o, 245);
      sleep_i = 1'b0;
      do_reset(mk(0, 4'h0, 4'h0, 2'b00, 0, 0));
      sleep_i = 1'b1;
      repeat (50) @(negedge clk);
      chk("R11 sleep ignored", count_o, 205);
      sleep_i = 1'b0;

      // R12 clock enable gating
      do_reset(mk(0, 4'h0, 4'h0, 2'b00, 0, 0));
      repeat (10) @(negedge clk);
      cnt_en_i = 1'b0;
      repeat (40) @(negedge clk);
      chk("R12 gated", count_o, 245);
      cnt_en_i = 1'b1;
      repeat (5) @(negedge clk);
      chk("R12 resumes", count_o, 240);

      // R13 service on the underflow tick
      do_reset(mk(0, 4'b0001, 4'h0, 2'b00, 0, 0));
      wait_count(1);
      kick(16'h0123);
      kick(16'h3210);
      chk("R13 service wins count", count_o, 255);
      chk("R13 service wins flags", flags_o, 0);
      do_reset(mk(0, 4'b1000, 4'h0, 2'b00, 1, 0));
      wait_count(1);
      kick(16'h0123);
      kick(16'h3210);
      chk("R13 both flags", flags_o, 2'b11);
      chk("R13 reload", count_o, 255);
      chk("R13 req pulse", rst_req_o, 1);
      @(negedge clk);
      chk("R13 single pulse", rst_req_o, 0);

      // R14 configuration frozen after reset
      do_reset(mk(0, 4'h0, 4'h0, 2'b11, 0, 0));
      cfg_i = mk(1, 4'b0001, 4'b1011, 2'b00, 1, 1);
      sleep_i = 1'b1;
      repeat (300) @(negedge clk);
      chk("R14 period and divider kept", count_o, 65535 - 300);
      chk("R14 no fault", {flags_o, rst_req_o}, 0);
      sleep_i = 1'b0;

      finish_run();
   end

endmodule